// File: doc/BRIEF.md
# Hit-Count and Header Word Serializer

When an event is accepted at Level 2, this block emits a fixed burst of seven 32-bit words into a count buffer through a simple word-write port. The first six words pack one 4-bit field for each of 48 channels: a channel-enable flag and a hit count clipped at four. The seventh and last word is the event header. It carries the bunch crossing number, the total number of hits in the data block, the L2 buffer slot, the chip serial bit, a constant type bit and a 9-bit module identifier.

All inputs are captured on the cycle a start strobe is accepted. The burst therefore describes one consistent snapshot, even if the upstream counters move on while it drains. The per-channel hit counts themselves are produced elsewhere. This block only clips, packs and orders them.

Top module: `hitcount_serializer`

## Requirements
- R1: Each accepted start produces exactly seven writes on consecutive cycles, at addresses 0,1,2,3,4,5,6 in that order. Address 6 is the header word and is always written last.
- R2: The word at address k (0 to 5) holds channels 8k to 8k+7. Channel 8k+j occupies bits 4j+3 down to 4j, so the lowest channel sits in bits 3..0 and the highest in bits 31..28.
- R3: In each channel field, bit 3 equals the channel's bit of `ch_enable`. Bits 2..0 equal the raw count when it is 4 or less, and 4 otherwise.
- R4: In the header, bits 7..0 hold `bx_count`, bits 17..8 hold `hit_total`, bits 19..18 hold `l2_slot`, and bit 20 is 0.
- R5: In the header, bit 21 holds `chip_sel`, bit 22 is 1, and bits 31..23 hold `module_id`.
- R6: All words of a burst reflect the input values present in the cycle the start was accepted. Input changes after that cycle have no effect on the burst.
- R7: The first write appears two clock edges after the edge that samples an accepted start. `done` is high for exactly one cycle, the cycle after the header write. `busy` is high from the cycle after acceptance through the header-write cycle.
- R8: A start sampled while `busy` is high is ignored. A start presented in the cycle `done` is high is accepted.
- R9: During and directly after reset, `wr_en`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Level-2 accept strobe that starts a burst |
| ch_count | input | 48*CNT_W | Raw hit count per channel, channel c at bits c*CNT_W upward |
| ch_enable | input | 48 | Channel on/off flags |
| bx_count | input | 8 | Bunch crossing counter |
| hit_total | input | 10 | Number of hits in the data block |
| l2_slot | input | 2 | L2 buffer number |
| chip_sel | input | 1 | Chip serial bit |
| module_id | input | 9 | Module identifier |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | 3 | Word address within the count buffer |
| wr_data | output | 32 | Word data |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the header write |

## Verification
Two things can fall in the same cycle. One is the `done` pulse that closes a burst. The other is a fresh start strobe, which the block must accept and open a new burst with no gap. The bench provokes this by holding `start` high for many cycles, so it lands both on the done cycle and on every busy cycle. The behavioural model then decides, cycle by cycle, which starts are accepted and which are ignored. The inputs are also changed during a running burst, to show that only the accepted snapshot reaches the words.

// File: rtl/hitcount_serializer.sv
module hitcount_serializer #(
  parameter int CNT_W = 4,
  localparam int NCH = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NCH*CNT_W-1:0] ch_count,
  input  logic [NCH-1:0]       ch_enable,
  input  logic [7:0]           bx_count,
  input  logic [9:0]           hit_total,
  input  logic [1:0]           l2_slot,
  input  logic                 chip_sel,
  input  logic [8:0]           module_id,
  output logic                 wr_en,
  output logic [2:0]           wr_addr,
  output logic [31:0]          wr_data,
  output logic                 busy,
  output logic                 done
);
  localparam int CAP = 4;
  localparam logic [2:0] HDR = 3'd6;

  logic [NCH*4-1:0] nib_d;
  logic [31:0]      hdr_d;
  logic [7:0][31:0] bank_q;
  logic             run;
  logic [2:0]       idx;
  logic             accept;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [CNT_W-1:0] raw;
    assign raw = ch_count[g*CNT_W +: CNT_W];
    assign nib_d[g*4 +: 4] = {ch_enable[g], (raw > CNT_W'(CAP)) ? 3'(CAP) : raw[2:0]};
  end

  assign hdr_d  = {module_id, 1'b1, chip_sel, 1'b0, l2_slot, hit_total, bx_count};
  assign accept = start && !run && !wr_en;
  assign busy   = run || wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      idx     <= 3'd0;
      wr_en   <= 1'b0;
      wr_addr <= 3'd0;
      wr_data <= 32'd0;
      done    <= 1'b0;
      bank_q  <= '0;
    end else begin
      done  <= wr_en && (wr_addr == HDR);
      wr_en <= run;
      if (run) begin
        wr_addr <= idx;
        wr_data <= bank_q[idx];
        idx     <= idx + 3'd1;
        if (idx == HDR) run <= 1'b0;
      end
      if (accept) begin
        run    <= 1'b1;
        idx    <= 3'd0;
        bank_q <= {32'd0, hdr_d, nib_d};
      end
    end
  end
endmodule

module hitcount_serializer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done
);
  function automatic logic caps_ok(logic [31:0] w);
    logic ok = 1'b1;
    for (int j = 0; j < 8; j++) if (w[4*j +: 3] > 3'd4) ok = 1'b0;
    return ok;
  endfunction

  p_next_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr != 3'd6 |=> wr_en && wr_addr == $past(wr_addr) + 3'd1);
  p_hdr_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd6 |=> !wr_en && done);
  p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr < 3'd6 |-> caps_ok(wr_data));
  p_hdr_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd6 |-> !wr_data[20] && wr_data[22]);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_first_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !wr_en ##1 wr_en && wr_addr == 3'd0);
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !(wr_en && wr_addr == 3'd6) |=> busy);
endmodule

bind hitcount_serializer hitcount_serializer_chk u_chk (.*);

// File: tb/tb_hitcount_serializer.sv
`timescale 1ns/1ps
module tb_hitcount_serializer;
  localparam int CNT_W = 4;
  localparam int NCH = 48;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [NCH*CNT_W-1:0] ch_count = '0;
  logic [NCH-1:0] ch_enable = '0;
  logic [7:0] bx_count = 0;
  logic [9:0] hit_total = 0;
  logic [1:0] l2_slot = 0;
  logic chip_sel = 0;
  logic [8:0] module_id = 0;
  logic wr_en, busy, done;
  logic [2:0] wr_addr;
  logic [31:0] wr_data;

  int compared = 0, mismatched = 0;

  logic m_wr = 0, m_busy = 0, m_done = 0;
  int m_addr = 0;
  logic [31:0] m_data = 0;
  logic [31:0] q[$];
  int qa[$];

  always #2.5 clk = ~clk;

  hitcount_serializer #(.CNT_W(CNT_W)) dut (.*);

  function automatic logic [31:0] ref_word(int k);
    logic [31:0] w = 0;
    if (k == 6) begin
      w[7:0] = bx_count; w[17:8] = hit_total; w[19:18] = l2_slot;
      w[20] = 0; w[21] = chip_sel; w[22] = 1; w[31:23] = module_id;
    end else
      for (int j = 0; j < 8; j++) begin
        int c = int'(ch_count[(8*k+j)*CNT_W +: CNT_W]);
        if (c > 4) c = 4;
        w[4*j+3] = ch_enable[8*k+j];
        w[4*j +: 3] = 3'(c);
      end
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic accept, n_done;
    chk("R1/R7 wr_en", 32'(wr_en), 32'(m_wr));
    chk("R7/R8 busy", 32'(busy), 32'(m_busy));
    chk("R7 done", 32'(done), 32'(m_done));
    if (m_wr) begin
      chk("R1 wr_addr", 32'(wr_addr), 32'(m_addr));
      chk(m_addr == 6 ? "R4/R5/R6 header" : "R2/R3/R6 count word", wr_data, m_data);
    end
    accept = start && !m_busy;
    n_done = m_wr && m_addr == 6;
    if (accept) begin
      for (int k = 0; k < 7; k++) begin q.push_back(ref_word(k)); qa.push_back(k); end
      m_wr = 0; m_busy = 1;
    end else if (q.size() > 0) begin
      m_data = q.pop_front(); m_addr = qa.pop_front(); m_wr = 1; m_busy = 1;
    end else begin
      m_wr = 0; m_busy = 0;
    end
    m_done = n_done;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rand_inputs();
    for (int c = 0; c < NCH; c++) ch_count[c*CNT_W +: CNT_W] = CNT_W'($urandom);
    ch_enable = {16'($urandom), 32'($urandom)};
    bx_count = 8'($urandom); hit_total = 10'($urandom); l2_slot = 2'($urandom);
    chip_sel = 1'($urandom); module_id = 9'($urandom);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk("R9 reset wr_en", 32'(wr_en), 0);
    chk("R9 reset busy", 32'(busy), 0);
    chk("R9 reset done", 32'(done), 0);
    rst_n = 1;
    step();
    // single event, mixed counts including values above 4 (R3)
    rand_inputs();
    ch_count[0 +: 4] = 4'd4; ch_count[4 +: 4] = 4'd5; ch_count[47*4 +: 4] = 4'd15;
    start = 1; step(); start = 0;
    repeat (12) step();
    // saturated counts, all enabled; inputs churn during the burst (R6)
    for (int c = 0; c < NCH; c++) ch_count[c*4 +: 4] = 4'hF;
    ch_enable = '1; module_id = 9'h1FF; chip_sel = 1; l2_slot = 3; hit_total = 10'h3FF; bx_count = 8'hFF;
    start = 1; step(); start = 0;
    for (int i = 0; i < 10; i++) begin rand_inputs(); step(); end
    // all disabled, ramp counts, zero header fields
    for (int c = 0; c < NCH; c++) ch_count[c*4 +: 4] = 4'(c % 8);
    ch_enable = '0; module_id = 0; chip_sel = 0; l2_slot = 0; hit_total = 0; bx_count = 0;
    start = 1; step(); start = 0;
    repeat (10) step();
    // start held: ignored while busy (R8), accepted back-to-back on done
    start = 1;
    for (int i = 0; i < 30; i++) begin rand_inputs(); step(); end
    start = 0;
    repeat (10) step();
    // random traffic
    for (int i = 0; i < 600; i++) begin
      rand_inputs();
      start = ($urandom % 4) == 0;
      step();
    end
    start = 0;
    repeat (12) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule